// File: doc/BRIEF.md
# Three-Wire Serial Configuration Register Loader

This block takes configuration words from a three-wire serial bus: an active-low frame enable, a data line and a bit clock. All three lines are sampled in the system clock domain and are assumed to be synchronised already. While the enable line is low, each rising edge of the bit clock pushes the data bit into a shift register. That register keeps only the most recent bits, up to the widest payload plus two.

When the enable line rises, the block decodes the two bits received last as a destination number. It then copies the payload bits that sit directly above them into one of four destination registers. Each destination has its own width. A one-cycle strobe marks the destination that was written.

Senders that pad frames to whole bytes put their fill bits first. Those bits fall off the top of the shift register, so padded and unpadded frames give the same result.

Top module: `ser3w_loader`

## Requirements
- R1: After synchronous reset, all four destination outputs, the internal shift register and `upd_valid` are zero.
- R2: A data bit is captured only on a rising edge of `sw_sclk`, using the value of `sw_dat` sampled on that edge. Changes of `sw_dat` while `sw_sclk` stays high have no effect.
- R3: While `sw_en` is high, `sw_sclk` and `sw_dat` are ignored and the shift register keeps its contents.
- R4: A rising edge of `sw_en` writes one destination. The destination number is {second-to-last bit, last bit} received, with 0 selecting `dest0_q`, 1 `dest1_q`, 2 `dest2_q` and 3 `dest3_q`.
- R5: The written value is made of the bits received just before the two address bits, sent most significant bit first. It is truncated to that destination's width (4, 6, 8 and 10 bits by default).
- R6: Bits sent before the last (widest width + 2) bits of a frame are discarded, so leading pad bits do not change the result.
- R7: Destinations that are not addressed keep their value across a transfer.
- R8: `upd_valid` is zero except for exactly one cycle per transfer. It then has only bit d set, where d is the destination written. It is seen in the cycle after the one in which `sw_en` is first sampled high.
- R9: A `sw_sclk` level held high for several system cycles shifts in exactly one bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_en | input | 1 | Frame enable: low while shifting, rising edge transfers |
| sw_sclk | input | 1 | Serial bit clock (sampled) |
| sw_dat | input | 1 | Serial data |
| dest0_q | output | W0 | Destination 0 contents |
| dest1_q | output | W1 | Destination 1 contents |
| dest2_q | output | W2 | Destination 2 contents |
| dest3_q | output | W3 | Destination 3 contents |
| upd_valid | output | 4 | One-cycle one-hot write strobe, bit d for destination d |

## Verification
The assertions check the following on every cycle:
- the strobe is never more than one-hot, lasts a single cycle and only follows a rising enable;
- no destination changes without its strobe bit;
- the shift register stays frozen whenever enable is high or the bit clock is sampled low.

The bench scenarios are needed to show that the right bits land in the right destination. This covers the address decode, bit order, truncation to each width, discarding of leading pad bits, and the ignored clocking while enable is high, which is brought out by a short follow-up frame.

// File: rtl/ser3w_pkg.sv
package ser3w_pkg;
  localparam int NUM_DEST = 4;
  localparam int ADDR_W   = 2;

  function automatic int max_of4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/s3w_edge.sv
module s3w_edge (
  input  logic clk,
  input  logic rst,
  input  logic sig,
  output logic rise
);
  logic prev_q;

  // Reset the history high so that a line idling high never fakes an edge.
  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= sig;
  end

  assign rise = sig & ~prev_q;
endmodule

// File: rtl/s3w_shifter.sv
module s3w_shifter #(
  parameter int DEPTH = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift,
  input  logic             din,
  output logic [DEPTH-1:0] sr
);
  always_ff @(posedge clk) begin
    if (rst)        sr <= '0;
    else if (shift) sr <= {sr[DEPTH-2:0], din};
  end
endmodule

// File: rtl/s3w_dest_latch.sv
module s3w_dest_latch
  import ser3w_pkg::*;
#(
  parameter int W   = 8,
  parameter int IDX = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] sel,
  input  logic [W-1:0]      src,
  output logic [W-1:0]      q,
  output logic              vld
);
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(IDX);

  logic hit;
  assign hit = load && (sel == MY_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      q   <= '0;
      vld <= 1'b0;
    end else begin
      vld <= hit;
      if (hit) q <= src;
    end
  end
endmodule

// File: rtl/ser3w_loader.sv
module ser3w_loader
  import ser3w_pkg::*;
#(
  parameter int W0 = 4,
  parameter int W1 = 6,
  parameter int W2 = 8,
  parameter int W3 = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sw_en,
  input  logic                sw_sclk,
  input  logic                sw_dat,
  output logic [W0-1:0]       dest0_q,
  output logic [W1-1:0]       dest1_q,
  output logic [W2-1:0]       dest2_q,
  output logic [W3-1:0]       dest3_q,
  output logic [NUM_DEST-1:0] upd_valid
);
  localparam int K    = max_of4(W0, W1, W2, W3);
  localparam int SR_W = K + ADDR_W;
  localparam int DW [NUM_DEST] = '{W0, W1, W2, W3};

  logic            sclk_rise;
  logic            en_rise;
  logic            shift_en;
  logic [SR_W-1:0] sr_q;

  s3w_edge u_sclk_edge (.clk(clk), .rst(rst), .sig(sw_sclk), .rise(sclk_rise));
  s3w_edge u_en_edge   (.clk(clk), .rst(rst), .sig(sw_en),   .rise(en_rise));

  // Shifting is gated by the enable level: high enable freezes the register.
  assign shift_en = sclk_rise & ~sw_en;

  s3w_shifter #(.DEPTH(SR_W)) u_shift (
    .clk(clk), .rst(rst), .shift(shift_en), .din(sw_dat), .sr(sr_q)
  );

  for (genvar g = 0; g < NUM_DEST; g++) begin : gen_dest
    localparam int WG = DW[g];
    logic [WG-1:0] q_g;
    logic          v_g;

    s3w_dest_latch #(.W(WG), .IDX(g)) u_lat (
      .clk(clk), .rst(rst), .load(en_rise),
      .sel(sr_q[ADDR_W-1:0]),
      .src(sr_q[WG+ADDR_W-1:ADDR_W]),
      .q(q_g), .vld(v_g)
    );

    assign upd_valid[g] = v_g;

    if (g == 0) begin : g_out0
      assign dest0_q = q_g;
    end else if (g == 1) begin : g_out1
      assign dest1_q = q_g;
    end else if (g == 2) begin : g_out2
      assign dest2_q = q_g;
    end else begin : g_out3
      assign dest3_q = q_g;
    end
  end
endmodule

// File: rtl/s3w_checker.sv
module s3w_checker #(
  parameter int W0   = 4,
  parameter int W1   = 6,
  parameter int W2   = 8,
  parameter int W3   = 10,
  parameter int SR_W = 12
) (
  input logic            clk,
  input logic            rst,
  input logic            sw_en,
  input logic            sw_sclk,
  input logic [W0-1:0]   dest0_q,
  input logic [W1-1:0]   dest1_q,
  input logic [W2-1:0]   dest2_q,
  input logic [W3-1:0]   dest3_q,
  input logic [3:0]      upd_valid,
  input logic [SR_W-1:0] sr
);
  AST_VALID_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(upd_valid)); // R8
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (|upd_valid) |=> (upd_valid == 4'b0000)); // R8
  AST_VALID_AFTER_EN_RISE: assert property (@(posedge clk) disable iff (rst)
    (|upd_valid) |-> ($past(sw_en) && !$past(sw_en, 2))); // R8
  AST_HOLD_DEST0: assert property (@(posedge clk) disable iff (rst)
    !upd_valid[0] |-> $stable(dest0_q)); // R7
  AST_HOLD_DEST1: assert property (@(posedge clk) disable iff (rst)
    !upd_valid[1] |-> $stable(dest1_q)); // R7
  AST_HOLD_DEST2: assert property (@(posedge clk) disable iff (rst)
    !upd_valid[2] |-> $stable(dest2_q)); // R7
  AST_HOLD_DEST3: assert property (@(posedge clk) disable iff (rst)
    !upd_valid[3] |-> $stable(dest3_q)); // R7
  AST_SR_FROZEN: assert property (@(posedge clk) disable iff (rst)
    ($past(sw_en) || !$past(sw_sclk)) |-> $stable(sr)); // R3
endmodule

bind ser3w_loader s3w_checker #(
  .W0(W0), .W1(W1), .W2(W2), .W3(W3), .SR_W(SR_W)
) u_chk (
  .clk(clk), .rst(rst), .sw_en(sw_en), .sw_sclk(sw_sclk),
  .dest0_q(dest0_q), .dest1_q(dest1_q), .dest2_q(dest2_q), .dest3_q(dest3_q),
  .upd_valid(upd_valid), .sr(sr_q)
);

// File: tb/ser3w_loader_test.sv
module ser3w_loader_test;
  localparam int K = 10;
  localparam int BW [4] = '{4, 6, 8, 10};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sw_en = 1'b1;
  logic       sw_sclk = 1'b1;
  logic       sw_dat = 1'b1;
  logic [3:0] d0;
  logic [5:0] d1;
  logic [7:0] d2;
  logic [9:0] d3;
  logic [3:0] upd_valid;

  int checks = 0;
  int failures = 0;
  int exp_q [4] = '{0, 0, 0, 0};
  bit done = 0;

  always #2 clk = ~clk;

  ser3w_loader uut (
    .clk(clk), .rst(rst), .sw_en(sw_en), .sw_sclk(sw_sclk), .sw_dat(sw_dat),
    .dest0_q(d0), .dest1_q(d1), .dest2_q(d2), .dest3_q(d3), .upd_valid(upd_valid)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int dest_val(input int d);
    case (d)
      0: return int'(d0);
      1: return int'(d1);
      2: return int'(d2);
      default: return int'(d3);
    endcase
  endfunction

  // One bit: data set with sclk low, then sclk held high three cycles while
  // the data line is flipped (R2, R9).
  task automatic send_bit(input logic b);
    @(negedge clk); sw_dat = b; sw_sclk = 1'b0;
    @(negedge clk);
    @(negedge clk); sw_sclk = 1'b1;
    @(negedge clk); sw_dat = ~b;
    @(negedge clk);
  endtask

  task automatic end_frame(input int dest, input string tag);
    @(negedge clk); sw_en = 1'b1;
    @(negedge clk);
    check("R8 strobe", int'(upd_valid), 1 << dest);
    @(negedge clk);
    check("R8 strobe clear", int'(upd_valid), 0);
    for (int d = 0; d < 4; d++) begin
      if (d == dest) check(tag, dest_val(d), exp_q[d]);
      else           check("R7 untouched", dest_val(d), exp_q[d]);
    end
  endtask

  task automatic send_frame(input int dest, input int val, input int pad);
    @(negedge clk); sw_en = 1'b0;
    for (int j = 0; j < pad; j++) send_bit(logic'((j + val) & 1));
    for (int j = K - 1; j >= 0; j--) send_bit(logic'((val >> j) & 1));
    send_bit(logic'((dest >> 1) & 1));
    send_bit(logic'(dest & 1));
    exp_q[dest] = val & ((1 << BW[dest]) - 1);
    end_frame(dest, (pad == 0) ? "R2 R4 R5 R9 payload" : "R6 padded payload");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [13:0] t;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    for (int d = 0; d < 4; d++) check("R1 reset dest", dest_val(d), 0);
    check("R1 reset strobe", int'(upd_valid), 0);

    // Sweep every destination with 16 payloads and pad lengths 0..3 (R4, R5, R6).
    for (int d = 0; d < 4; d++)
      for (int i = 0; i < 16; i++)
        send_frame(d, (i * 11 + d * 97 + 3) & ((1 << K) - 1), i % 4);

    // R3: known frame to dest3, clocking with enable high, then an
    // address-only frame exposes the shift register contents.
    send_frame(3, 10'h2A5, 0);
    for (int j = 0; j < 6; j++) send_bit(logic'(j & 1));
    @(negedge clk); sw_en = 1'b0;
    send_bit(1'b1);
    send_bit(1'b1);
    t = {10'h2A5, 4'b1111};
    exp_q[3] = int'(t[11:2]);
    end_frame(3, "R3 ignored while enable high");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule